// File: doc/BRIEF.md
# Three-Wire Serial Register Access Master

This block turns single register requests from a parallel host port into bit-serial frames on a three-wire configuration bus. The bus has a chip select, a serial clock and one data line. The data line is bidirectional and appears at the ports as a driven value, a drive enable and a sampled input. The host presents an address, a write flag and 16 bits of write data, then pulses start. The block sends the frame and finishes with a one-cycle done pulse. For a read, the selected 16-bit value is then on the read-data port.

Writes and reads use different frames. A write is short, is framed by chip select, and carries both address and data. A read keeps chip select low and begins with a long preamble. After the frame the block releases the line, waits two clocks and shifts in a 32-bit register pair. The address LSB then selects one half of the pair.

All serial timing is counted in phases. A phase is `PHASE_CYC` system clock cycles, so the serial clock can be slowed to the few-microsecond edges a slow device needs.

Top module: `ser_reg_master`

## Requirements
- R1: After reset, `cs_o`, `sck_o`, `sd_o`, `sd_oe_o`, `busy_o` and `done_o` are all low and `rdata_o` is zero.
- R2: A write sends 27 bits, most significant first: 1, then 0,1, then `addr_i[7:0]`, then `wdata_i[15:0]`. `cs_o` is high from the setup phase through the closing low phase after the last bit. It is low during the two trailing clocks.
- R3: A read sends 46 bits, most significant first, with `cs_o` low for the whole transaction. The bits are 32 ones, then 0,1, then 1,0, then 0, then 0,0, then `addr_i[6:0]`. `addr_i[7]` is not sent.
- R4: Every phase lasts exactly `PHASE_CYC` clock cycles. A transaction opens with one setup phase in which `sck_o` is low. Each output bit takes one low phase, in which `sd_o` takes the new bit, followed by one high phase in which the bit is held.
- R5: A read frame is followed by one closing low phase. The line is then released and two clocks are given (high, low, high, low). Then come 32 input bits. For each input bit, `sd_i` is sampled at the end of its low phase, and a high phase follows. One more low phase comes after the 32nd bit.
- R6: When a read completes, `rdata_o` takes the first 16 received bits if `addr_i[0]` was 1, and the last 16 bits if it was 0, in both cases first-received bit in the MSB. A write leaves `rdata_o` unchanged.
- R7: Every transaction ends with two extra clocks (high, low, high, low), and `sck_o` is low when it finishes.
- R8: `sd_oe_o` is high only in the setup phase, the output bit phases and the closing low phase after the last output bit. `sd_o` is low whenever no output bit is being shifted.
- R9: `busy_o` goes high in the cycle after an accepted start and stays high through the last phase. `done_o` is high for exactly one cycle after the last phase, with `busy_o` already low.
- R10: A start pulse while `busy_o` is high is ignored, together with its address, data and write flag. The running frame and its read result are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, accepted when idle |
| write_i | input | 1 | 1 = write transaction, 0 = read |
| addr_i | input | 8 | Register address |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Last read result |
| cs_o | output | 1 | Serial chip select |
| sck_o | output | 1 | Serial clock |
| sd_o | output | 1 | Serial data driven value |
| sd_oe_o | output | 1 | Serial data drive enable |
| sd_i | input | 1 | Serial data sampled value |

## Verification
The bench builds the block with `PHASE_CYC` = 3. Each phase is then three cycles long, so an off-by-one in the phase counter shows up as a shifted edge. A full 167-phase read also stays within a few hundred cycles. This makes it cheap to run writes, reads at odd and even addresses (one with bit 7 set), back-to-back requests and a start injected mid-read, and to compare every pin on every cycle.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 16;
  localparam int WR_BITS  = 27;
  localparam int RD_BITS  = 46;
  localparam int PRE_BITS = 32;
  localparam int IN_BITS  = 2 * DATA_W;
  localparam int SH_W     = RD_BITS;
  localparam int CNT_W    = $clog2(SH_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_OUT, ST_OUT_END, ST_TURN, ST_IN, ST_IN_END, ST_TAIL
  } ser_st_e;

  // write frame left-aligned in the shifter
  function automatic logic [SH_W-1:0] wr_frame(input logic [ADDR_W-1:0] a,
                                                input logic [DATA_W-1:0] d);
    return {1'b1, 2'b01, a, d, {(SH_W-WR_BITS){1'b0}}};
  endfunction

  function automatic logic [SH_W-1:0] rd_frame(input logic [6:0] a);
    return {{PRE_BITS{1'b1}}, 2'b01, 2'b10, 1'b0, 2'b00, a};
  endfunction
endpackage

// File: rtl/ser_phase_tick.sv
module ser_phase_tick #(
  parameter int PHASE_CYC = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!en_i || cnt_q == LAST)  cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/ser_shift_unit.sv
module ser_shift_unit #(
  parameter int OUT_W = 46,
  parameter int IN_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [OUT_W-1:0] load_val_i,
  input  logic             shift_i,
  input  logic             sample_i,
  input  logic             sd_i,
  output logic             msb_o,
  output logic [IN_W-1:0]  cap_o
);
  logic [OUT_W-1:0] out_q;
  logic [IN_W-1:0]  in_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       out_q <= '0;
    else if (load_i)   out_q <= load_val_i;
    else if (shift_i)  out_q <= {out_q[OUT_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        in_q <= '0;
    else if (sample_i)  in_q <= {in_q[IN_W-2:0], sd_i};
  end

  assign msb_o = out_q[OUT_W-1];
  assign cap_o = in_q;
endmodule

// File: rtl/ser_reg_master.sv
module ser_reg_master import ser_reg_pkg::*; #(
  parameter int PHASE_CYC = 300
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cs_o,
  output logic              sck_o,
  output logic              sd_o,
  output logic              sd_oe_o,
  input  logic              sd_i
);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_BITS - 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_BITS - 1);
  localparam logic [CNT_W-1:0] IN_LAST = CNT_W'(IN_BITS - 1);

  ser_st_e           st_q;
  logic              half_q;   // 0 = low phase, 1 = high phase
  logic [CNT_W-1:0]  bit_q;
  logic [1:0]        pc_q;     // idle-clock phase index
  logic              write_q, odd_q, done_q;
  logic [DATA_W-1:0] rdata_q;

  logic             tick, load, shift, sample, msb;
  logic [SH_W-1:0]  load_val;
  logic [IN_BITS-1:0] cap;
  logic [CNT_W-1:0] out_last;

  assign load     = (st_q == ST_IDLE) && start_i;
  assign load_val = write_i ? wr_frame(addr_i, wdata_i) : rd_frame(addr_i[6:0]);
  assign shift    = tick && (st_q == ST_OUT) && half_q;
  assign sample   = tick && (st_q == ST_IN) && !half_q;
  assign out_last = write_q ? WR_LAST : RD_LAST;

  ser_phase_tick #(.PHASE_CYC(PHASE_CYC)) tick_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (st_q != ST_IDLE),
    .tick_o (tick)
  );

  ser_shift_unit #(.OUT_W(SH_W), .IN_W(IN_BITS)) shift_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .shift_i    (shift),
    .sample_i   (sample),
    .sd_i       (sd_i),
    .msb_o      (msb),
    .cap_o      (cap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      half_q  <= 1'b0;
      bit_q   <= '0;
      pc_q    <= '0;
      write_q <= 1'b0;
      odd_q   <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        st_q    <= ST_SETUP;
        write_q <= write_i;
        odd_q   <= addr_i[0];
      end else if (tick) begin
        unique case (st_q)
          ST_SETUP: begin
            st_q   <= ST_OUT;
            half_q <= 1'b0;
            bit_q  <= '0;
          end
          ST_OUT: begin
            half_q <= ~half_q;
            if (half_q) begin
              if (bit_q == out_last) st_q <= ST_OUT_END;
              else                   bit_q <= bit_q + 1'b1;
            end
          end
          ST_OUT_END: begin
            st_q <= write_q ? ST_TAIL : ST_TURN;
            pc_q <= '0;
          end
          ST_TURN: begin
            pc_q <= pc_q + 1'b1;
            if (pc_q == 2'd3) begin
              st_q   <= ST_IN;
              half_q <= 1'b0;
              bit_q  <= '0;
            end
          end
          ST_IN: begin
            half_q <= ~half_q;
            if (half_q) begin
              if (bit_q == IN_LAST) st_q <= ST_IN_END;
              else                  bit_q <= bit_q + 1'b1;
            end
          end
          ST_IN_END: begin
            st_q <= ST_TAIL;
            pc_q <= '0;
          end
          ST_TAIL: begin
            pc_q <= pc_q + 1'b1;
            if (pc_q == 2'd3) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              if (!write_q)
                rdata_q <= odd_q ? cap[IN_BITS-1:DATA_W] : cap[DATA_W-1:0];
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    sd_oe_o = (st_q == ST_SETUP) || (st_q == ST_OUT) || (st_q == ST_OUT_END);
    cs_o    = write_q && sd_oe_o;
    sd_o    = (st_q == ST_OUT) && msb;
    unique case (st_q)
      ST_OUT, ST_IN:    sck_o = half_q;
      ST_TURN, ST_TAIL: sck_o = ~pc_q[0];
      default:          sck_o = 1'b0;
    endcase
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/ser_reg_master_chk.sv
module ser_reg_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic cs_o,
  input logic sck_o,
  input logic sd_o,
  input logic sd_oe_o
);
  // R9
  done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  busy_from_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R7
  end_clock_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (!sck_o && !cs_o));
  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sck_o && !cs_o && !sd_oe_o));
  // R8
  released_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sd_oe_o |-> !sd_o);
  // R2
  cs_with_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |-> sd_oe_o);
endmodule

bind ser_reg_master ser_reg_master_chk chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .cs_o    (cs_o),
  .sck_o   (sck_o),
  .sd_o    (sd_o),
  .sd_oe_o (sd_oe_o)
);

// File: tb/ser_reg_master_tb_top.sv
module ser_reg_master_tb_top;
  localparam int P = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        write_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        sd_i = 1'b0;
  logic        busy_o, done_o, cs_o, sck_o, sd_o, sd_oe_o;
  logic [15:0] rdata_o;

  int checks = 0;
  int fails = 0;
  logic [15:0] exp_rdata = '0;

  // per-phase reference: {cs, sck, oe, sd}
  logic [3:0] ph_q[$];
  int         drv_q[$];
  string      tag_q[$];

  always #5 clk_i = ~clk_i;

  ser_reg_master #(.PHASE_CYC(P)) dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .write_i (write_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .rdata_o (rdata_o),
    .cs_o    (cs_o),
    .sck_o   (sck_o),
    .sd_o    (sd_o),
    .sd_oe_o (sd_oe_o),
    .sd_i    (sd_i)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic add(logic cs, logic sck, logic oe, logic sd, int drv, string tag);
    ph_q.push_back({cs, sck, oe, sd});
    drv_q.push_back(drv);
    tag_q.push_back(tag);
  endtask

  task automatic two_clocks(string tag);
    for (int k = 0; k < 2; k++) begin
      add(1'b0, 1'b1, 1'b0, 1'b0, -1, tag);
      add(1'b0, 1'b0, 1'b0, 1'b0, -1, tag);
    end
  endtask

  task automatic txn(bit wr, logic [7:0] a, logic [15:0] wd, logic [31:0] slv, bit poke);
    bit bits[$];
    string ftag;
    ph_q.delete(); drv_q.delete(); tag_q.delete();
    ftag = wr ? "R2" : "R3";
    if (wr) begin
      bits.push_back(1); bits.push_back(0); bits.push_back(1);
      for (int i = 7; i >= 0; i--) bits.push_back(a[i]);
      for (int i = 15; i >= 0; i--) bits.push_back(wd[i]);
    end else begin
      for (int i = 0; i < 32; i++) bits.push_back(1);
      bits.push_back(0); bits.push_back(1); bits.push_back(1); bits.push_back(0);
      bits.push_back(0); bits.push_back(0); bits.push_back(0);
      for (int i = 6; i >= 0; i--) bits.push_back(a[i]);
    end
    add(wr, 1'b0, 1'b1, 1'b0, -1, "R4");
    foreach (bits[i]) begin
      add(wr, 1'b0, 1'b1, bits[i], -1, ftag);
      add(wr, 1'b1, 1'b1, bits[i], -1, ftag);
    end
    add(wr, 1'b0, 1'b1, 1'b0, -1, "R8");
    if (!wr) begin
      two_clocks("R5");
      for (int i = 31; i >= 0; i--) begin
        add(1'b0, 1'b0, 1'b0, 1'b0, int'(slv[i]), "R5");
        add(1'b0, 1'b1, 1'b0, 1'b0, -1, "R5");
      end
      add(1'b0, 1'b0, 1'b0, 1'b0, -1, "R5");
      exp_rdata = a[0] ? slv[31:16] : slv[15:0];
    end
    two_clocks("R7");

    @(negedge clk_i);
    start_i = 1'b1; write_i = wr; addr_i = a; wdata_i = wd;
    foreach (ph_q[p]) begin
      for (int c = 0; c < P; c++) begin
        @(negedge clk_i);
        start_i = poke && (p == 20) && (c == 0);
        if (start_i) begin
          write_i = ~wr; addr_i = ~a; wdata_i = ~wd;
        end
        if (c == 0 && drv_q[p] >= 0) sd_i = drv_q[p][0];
        chk(poke ? "R10" : tag_q[p], 64'({cs_o, sck_o, sd_oe_o, sd_o, busy_o, done_o}),
            64'({ph_q[p], 2'b10}));
      end
    end
    start_i = 1'b0;
    @(negedge clk_i);
    chk("R9 done", 64'({busy_o, done_o}), 64'(2'b01));
    chk(poke ? "R10 rdata" : "R6 rdata", 64'(rdata_o), 64'(exp_rdata));
    @(negedge clk_i);
    chk("R9 pulse", 64'({busy_o, done_o}), 64'(2'b00));
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL R9 watchdog expired: busy=%b expected done", busy_o);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 pins", 64'({cs_o, sck_o, sd_o, sd_oe_o, busy_o, done_o}), 64'(0));
    chk("R1 rdata", 64'(rdata_o), 64'(0));
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", 64'({cs_o, sck_o, sd_o, sd_oe_o, busy_o, done_o}), 64'(0));

    txn(1'b1, 8'hA5, 16'h3C96, 32'h0, 1'b0);
    chk("R6 write keeps rdata", 64'(rdata_o), 64'(0));
    txn(1'b0, 8'h13, 16'h0, 32'hDEAD_BEEF, 1'b0);       // odd: first half
    txn(1'b0, 8'h92, 16'h0, 32'h1234_5678, 1'b0);       // even, bit 7 not sent
    txn(1'b1, 8'h5A, 16'hFFFF, 32'h0, 1'b0);
    chk("R6 write keeps rdata", 64'(rdata_o), 64'(16'h5678));
    txn(1'b0, 8'h7F, 16'h0, 32'hF0F0_0F0F, 1'b1);       // start injected mid-read
    txn(1'b1, 8'h00, 16'h0001, 32'h0, 1'b1);
    chk("R10 rdata after write", 64'(rdata_o), 64'(16'hF0F0));
    summary();
  end
endmodule